// File: doc/BRIEF.md
# Dual-Channel Disk Interface Glue

This block is the card-side register logic of an expansion board that carries two disk drive interfaces behind one byte-wide synchronous host bus. It decodes the host address into per-channel task-file windows, per-channel control registers, per-channel interrupt arming and status bytes, a strided 4-bit board identification pattern, and a configuration latch. Task-file and control accesses are passed to the drive side as chip selects, a register index and read/write strobes.

Each drive's interrupt line is gated by an arm flag and the gated lines are merged into one host interrupt. A channel is armed by any write to its arm address and disarmed by a read of the same address. The configuration latch opens the task-file windows and steers the single DMA request/acknowledge pair to one of the two channels.

Top module: `dd_disk_glue`

## Requirements
- R1: After reset both arm flags are clear, the configuration latch holds 0x00, `host_irq` is low and `bus_rdata` is 0x00.
- R2: A write of any value to the arm address (channel 0: 0x2200, channel 1: 0x3200) arms that channel from the next cycle; `host_irq` is the OR over channels of (arm flag AND `drv_irq[ch]`).
- R3: A read of a channel's arm address disarms that channel from the next cycle and returns 0x00.
- R4: The status byte (channel 0: 0x2290, channel 1: 0x3290) returns `drv_irq[ch]` in bit 0, whether armed or not, and zero in bits 7..1.
- R5: The bytes at 0x2280, 0x2284, 0x2288 and 0x228C return in bit 0 the board type bits 0, 1, 2 and 3 respectively (type 3, so 1, 1, 0, 0), other bits zero.
- R6: The configuration latch at 0x0000 stores the written byte and reads it back; bit 5 opens the task-file windows, bit 0 selects DMA channel 1 (set) or channel 0 (clear).
- R7: With latch bit 5 set, an access to 0x2000 + 64*i (channel 0) or 0x3000 + 64*i (channel 1), i = 0..7, asserts `cs_tf[ch]`, drives `tf_idx` = i and the matching `drv_rd`/`drv_wr` strobe in the same cycle, passes `bus_wdata` to `drv_wdata`, and a read returns `drv_rdata`.
- R8: With latch bit 5 set, an access to 0x2380 (channel 0) or 0x3380 (channel 1) asserts `cs_ctl[ch]` with the drive strobe.
- R9: With latch bit 5 clear, task-file and control addresses assert no chip select or drive strobe and read 0x00.
- R10: At most one of the four chip selects is active in any cycle.
- R11: Any address outside the decoded set, including task-file addresses whose low 6 bits are not zero, reads 0x00 and a write there changes nothing.
- R12: `host_dreq` follows `dreq_in` of the channel picked by latch bit 0, and `dack_out` carries `host_dack` to that channel only.
- R13: Read data appears on `bus_rdata` in the cycle after the read strobe and holds until the next read; a cycle with both `bus_rd` and `bus_wr` high is no access at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (14) | Host byte address |
| bus_rd | input | 1 | Host read strobe |
| bus_wr | input | 1 | Host write strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, registered |
| drv_irq | input | 2 | Drive interrupt lines, one per channel |
| host_irq | output | 1 | Merged gated interrupt to host |
| cs_tf | output | 2 | Task-file chip select per channel |
| cs_ctl | output | 2 | Control register chip select per channel |
| tf_idx | output | 3 | Task-file register index |
| drv_rd | output | 1 | Drive-side read strobe |
| drv_wr | output | 1 | Drive-side write strobe |
| drv_wdata | output | 8 | Drive-side write data |
| drv_rdata | input | 8 | Drive-side read data |
| dreq_in | input | 2 | DMA request per channel |
| host_dreq | output | 1 | Routed DMA request to host |
| host_dack | input | 1 | DMA acknowledge from host |
| dack_out | output | 2 | Routed DMA acknowledge per channel |

## Verification
A wrong arm flag shows on `host_irq` one cycle after the arming write or disarming read, as soon as the drive line of that channel is driven; the bench toggles each line separately so a swapped or stuck flag is exposed. A wrong latch value shows at once on chip selects and DMA routing and, through readback of 0x0000, on the next read. Decode errors appear in the same cycle on the chip selects and one cycle later on `bus_rdata`, which the bench compares from an expectation queue.

// File: rtl/dd_glue_pkg.sv
package dd_glue_pkg;

    localparam int DEC_W      = 14;
    localparam int NCH        = 2;
    localparam int TF_STEP    = 6;
    localparam int TF_REGS    = 8;
    localparam int IDX_W      = $clog2(TF_REGS);

    localparam logic [11:0] ARM_OFS  = 12'h200;
    localparam logic [11:0] STAT_OFS = 12'h290;
    localparam logic [11:0] CTL_OFS  = 12'h380;
    localparam logic [7:0]  ID_HI    = 8'h28;

    localparam logic [3:0]  BOARD_TYPE = 4'd3;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_CFG,
        RG_TF,
        RG_CTL,
        RG_ARM,
        RG_STAT,
        RG_ID
    } region_e;

    typedef struct packed {
        region_e          region;
        logic             chan;
        logic [IDX_W-1:0] idx;
    } dec_t;

    function automatic dec_t decode_addr(input logic [DEC_W-1:0] a);
        dec_t d;
        logic [11:0] ofs;
        d.region = RG_NONE;
        d.chan   = 1'b0;
        d.idx    = '0;
        ofs      = a[11:0];
        if (a == '0) begin
            d.region = RG_CFG;
        end else if (a[13]) begin
            d.chan = a[12];
            if (ofs[TF_STEP-1:0] == '0 && ofs[11:TF_STEP] < TF_REGS) begin
                d.region = RG_TF;
                d.idx    = ofs[TF_STEP+IDX_W-1:TF_STEP];
            end else if (ofs == ARM_OFS) begin
                d.region = RG_ARM;
            end else if (ofs == STAT_OFS) begin
                d.region = RG_STAT;
            end else if (ofs == CTL_OFS) begin
                d.region = RG_CTL;
            end else if (!a[12] && ofs[11:4] == ID_HI && ofs[1:0] == 2'b00) begin
                d.region = RG_ID;
                d.idx    = {1'b0, ofs[3:2]};
            end
        end
        return d;
    endfunction

    function automatic logic [7:0] id_byte(input logic [1:0] sel);
        return {7'b0, BOARD_TYPE[sel]};
    endfunction

endpackage

// File: rtl/dd_addr_decode.sv
module dd_addr_decode
    import dd_glue_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output dec_t              dec,
    output logic              acc_rd,
    output logic              acc_wr
);
    localparam int HI_W = ADDR_W - DEC_W;

    logic upper_zero;

    generate
        if (HI_W > 0) begin : g_wide
            assign upper_zero = (addr[ADDR_W-1:DEC_W] == '0);
        end else begin : g_exact
            assign upper_zero = 1'b1;
        end
    endgenerate

    always_comb begin
        dec = decode_addr(addr[DEC_W-1:0]);
        if (!upper_zero) begin
            dec.region = RG_NONE;
        end
    end

    assign acc_rd = rd && !wr;
    assign acc_wr = wr && !rd;

endmodule

// File: rtl/dd_irq_ctrl.sv
module dd_irq_ctrl
    import dd_glue_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] arm_set,
    input  logic [NCH-1:0] arm_clr,
    input  logic [NCH-1:0] drv_irq,
    output logic [NCH-1:0] armed,
    output logic           host_irq
);
    logic [NCH-1:0] gated;

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            always_ff @(posedge clk) begin
                if (rst) begin
                    armed[c] <= 1'b0;
                end else if (arm_set[c]) begin
                    armed[c] <= 1'b1;
                end else if (arm_clr[c]) begin
                    armed[c] <= 1'b0;
                end
            end
            assign gated[c] = armed[c] & drv_irq[c];
        end
    endgenerate

    assign host_irq = |gated;

endmodule

// File: rtl/dd_cfg_dma.sv
module dd_cfg_dma
    import dd_glue_pkg::*;
#(
    parameter int EXT_BIT = 5,
    parameter int SEL_BIT = 0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_we,
    input  logic [7:0]     cfg_wdata,
    output logic [7:0]     cfg_q,
    output logic           ext_en,
    input  logic [NCH-1:0] dreq_in,
    input  logic           host_dack,
    output logic           host_dreq,
    output logic [NCH-1:0] dack_out
);
    logic dma_ch;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= 8'h00;
        end else if (cfg_we) begin
            cfg_q <= cfg_wdata;
        end
    end

    assign ext_en    = cfg_q[EXT_BIT];
    assign dma_ch    = cfg_q[SEL_BIT];
    assign host_dreq = dreq_in[dma_ch];

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ack
            assign dack_out[c] = host_dack && (dma_ch == c[0]);
        end
    endgenerate

endmodule

// File: rtl/dd_disk_glue.sv
module dd_disk_glue
    import dd_glue_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [1:0]        drv_irq,
    output logic              host_irq,
    output logic [1:0]        cs_tf,
    output logic [1:0]        cs_ctl,
    output logic [2:0]        tf_idx,
    output logic              drv_rd,
    output logic              drv_wr,
    output logic [7:0]        drv_wdata,
    input  logic [7:0]        drv_rdata,
    input  logic [1:0]        dreq_in,
    output logic              host_dreq,
    input  logic              host_dack,
    output logic [1:0]        dack_out
);
    dec_t           dec;
    logic           acc_rd;
    logic           acc_wr;
    logic [7:0]     cfg_q;
    logic           ext_en;
    logic [NCH-1:0] armed;
    logic [NCH-1:0] arm_set;
    logic [NCH-1:0] arm_clr;
    logic           drv_hit;
    logic [7:0]     rd_mux;
    logic [7:0]     rdata_q;

    dd_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr   (bus_addr),
        .rd     (bus_rd),
        .wr     (bus_wr),
        .dec    (dec),
        .acc_rd (acc_rd),
        .acc_wr (acc_wr)
    );

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_arm
            logic hit;
            assign hit        = (dec.region == RG_ARM) && (dec.chan == c[0]);
            assign arm_set[c] = hit && acc_wr;
            assign arm_clr[c] = hit && acc_rd;
            assign cs_tf[c]   = ext_en && (acc_rd || acc_wr) &&
                                (dec.region == RG_TF) && (dec.chan == c[0]);
            assign cs_ctl[c]  = ext_en && (acc_rd || acc_wr) &&
                                (dec.region == RG_CTL) && (dec.chan == c[0]);
        end
    endgenerate

    dd_irq_ctrl u_irq (
        .clk      (clk),
        .rst      (rst),
        .arm_set  (arm_set),
        .arm_clr  (arm_clr),
        .drv_irq  (drv_irq),
        .armed    (armed),
        .host_irq (host_irq)
    );

    dd_cfg_dma u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (acc_wr && dec.region == RG_CFG),
        .cfg_wdata (bus_wdata),
        .cfg_q     (cfg_q),
        .ext_en    (ext_en),
        .dreq_in   (dreq_in),
        .host_dack (host_dack),
        .host_dreq (host_dreq),
        .dack_out  (dack_out)
    );

    assign drv_hit   = (cs_tf != '0) || (cs_ctl != '0);
    assign drv_rd    = drv_hit && acc_rd;
    assign drv_wr    = drv_hit && acc_wr;
    assign drv_wdata = bus_wdata;
    assign tf_idx    = (dec.region == RG_TF) ? dec.idx : '0;

    always_comb begin
        unique case (dec.region)
            RG_CFG:        rd_mux = cfg_q;
            RG_TF, RG_CTL: rd_mux = ext_en ? drv_rdata : 8'h00;
            RG_STAT:       rd_mux = {7'b0, drv_irq[dec.chan]};
            RG_ID:         rd_mux = id_byte(dec.idx[1:0]);
            default:       rd_mux = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= 8'h00;
        end else if (acc_rd) begin
            rdata_q <= rd_mux;
        end
    end

    assign bus_rdata = rdata_q;

endmodule

// File: rtl/dd_glue_checker.sv
module dd_glue_checker #(
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [1:0]        drv_irq,
    input logic              host_irq,
    input logic [1:0]        cs_tf,
    input logic [1:0]        cs_ctl,
    input logic              drv_rd,
    input logic              drv_wr,
    input logic              host_dack,
    input logic [1:0]        dack_out,
    input logic [7:0]        cfg_q
);
    localparam logic [ADDR_W-1:0] ARM0 = ADDR_W'(14'h2200);

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cs_tf, cs_ctl})); // R10

    AST_IRQ_ARM: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_rd && bus_addr == ARM0) |=> (drv_irq[0] |-> host_irq)); // R2

    AST_IRQ_DISARM: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr == ARM0) |=> ((drv_irq == 2'b01) |-> !host_irq)); // R3

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
        host_irq |-> (drv_irq != 2'b00)); // R2

    AST_WINDOW_GATE: assert property (@(posedge clk) disable iff (rst)
        ((cs_tf != 2'b00) || (cs_ctl != 2'b00)) |-> cfg_q[5]); // R9

    AST_DACK_ROUTE: assert property (@(posedge clk) disable iff (rst)
        (dack_out != 2'b00) |-> (host_dack && $onehot(dack_out) && dack_out[cfg_q[0]])); // R12

    AST_STROBE_CLASH: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_wr) |-> (!drv_rd && !drv_wr)); // R13

endmodule

bind dd_disk_glue dd_glue_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .drv_irq   (drv_irq),
    .host_irq  (host_irq),
    .cs_tf     (cs_tf),
    .cs_ctl    (cs_ctl),
    .drv_rd    (drv_rd),
    .drv_wr    (drv_wr),
    .host_dack (host_dack),
    .dack_out  (dack_out),
    .cfg_q     (cfg_q)
);

// File: tb/test_dd_disk_glue.sv
module test_dd_disk_glue;
    localparam int PERIOD = 10;
    localparam int AW     = 14;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_rd = 1'b0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic [1:0]    drv_irq = '0;
    logic          host_irq;
    logic [1:0]    cs_tf;
    logic [1:0]    cs_ctl;
    logic [2:0]    tf_idx;
    logic          drv_rd;
    logic          drv_wr;
    logic [7:0]    drv_wdata;
    logic [7:0]    drv_rdata = '0;
    logic [1:0]    dreq_in = '0;
    logic          host_dreq;
    logic          host_dack = 1'b0;
    logic [1:0]    dack_out;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_d = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    dd_disk_glue #(.ADDR_W(AW)) i_dd_disk_glue (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected read data the cycle after each read strobe
    always @(posedge clk) rd_d <= bus_rd && !bus_wr && !rst;
    always @(negedge clk) begin
        if (rd_d) begin
            if (exp_q.size() == 0) begin
                chk("R13 unexpected read", 1, 0);
            end else begin
                chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic start(input logic [AW-1:0] a, input logic r, input logic w,
                         input logic [7:0] d, input logic [7:0] exp, input string tag);
        @(negedge clk);
        #1;
        bus_addr = a; bus_rd = r; bus_wr = w; bus_wdata = d;
        if (r && !w) begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
        end
        #1;
    endtask

    task automatic finish_acc();
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        start(a, 1'b0, 1'b1, d, 8'h00, "");
        finish_acc();
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
        start(a, 1'b1, 1'b0, 8'h00, exp, tag);
        finish_acc();
    endtask

    task automatic settle();
        @(negedge clk);
        #2;
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        settle();
        // R1 reset state
        chk("R1 rdata", bus_rdata, 8'h00);
        drv_irq = 2'b11; #1;
        chk("R1 host_irq", host_irq, 0);
        rd(14'h0000, 8'h00, "R1 latch");

        // R5 board identity
        rd(14'h2280, 8'h01, "R5 bit0");
        rd(14'h2284, 8'h01, "R5 bit1");
        rd(14'h2288, 8'h00, "R5 bit2");
        rd(14'h228C, 8'h00, "R5 bit3");
        rd(14'h3280, 8'h00, "R11 no id on ch1");

        // R4 status
        drv_irq = 2'b01;
        rd(14'h2290, 8'h01, "R4 ch0 set");
        rd(14'h3290, 8'h00, "R4 ch1 clear");
        drv_irq = 2'b10;
        rd(14'h3290, 8'h01, "R4 ch1 set");
        rd(14'h2290, 8'h00, "R4 ch0 clear");

        // R2 / R3 arming
        drv_irq = 2'b00;
        wr(14'h2200, 8'h00);
        settle();
        drv_irq = 2'b01; #1;
        chk("R2 ch0 armed", host_irq, 1);
        drv_irq = 2'b10; #1;
        chk("R2 ch1 not armed", host_irq, 0);
        wr(14'h3200, 8'h5A);
        settle();
        chk("R2 ch1 armed", host_irq, 1);
        rd(14'h2200, 8'h00, "R3 read returns zero");
        settle();
        drv_irq = 2'b01; #1;
        chk("R3 ch0 disarmed", host_irq, 0);
        drv_irq = 2'b10; #1;
        chk("R3 ch1 still armed", host_irq, 1);

        // R13 clash: both strobes on ch1 arm address must not disarm
        start(14'h3200, 1'b1, 1'b1, 8'h00, 8'h00, "");
        chk("R13 clash no drv strobe", {drv_rd, drv_wr}, 0);
        finish_acc();
        settle();
        chk("R13 clash kept arm", host_irq, 1);

        // R9 closed window
        drv_rdata = 8'h3C;
        start(14'h2040, 1'b1, 1'b0, 8'h00, 8'h00, "R9 closed read");
        chk("R9 no cs", {cs_tf, cs_ctl, drv_rd}, 0);
        finish_acc();

        // R6 latch
        wr(14'h0000, 8'h20);
        rd(14'h0000, 8'h20, "R6 latch readback");

        // R7 task file
        start(14'h3080, 1'b0, 1'b1, 8'hA5, 8'h00, "");
        chk("R7 cs ch1", cs_tf, 2'b10);
        chk("R7 idx", tf_idx, 2);
        chk("R7 wr strobe", {drv_wr, drv_rd}, 2'b10);
        chk("R7 wdata", drv_wdata, 8'hA5);
        finish_acc();
        start(14'h21C0, 1'b1, 1'b0, 8'h00, 8'h3C, "R7 read data");
        chk("R7 cs ch0", cs_tf, 2'b01);
        chk("R7 idx7", tf_idx, 7);
        chk("R7 rd strobe", {drv_wr, drv_rd}, 2'b01);
        finish_acc();

        // R8 control
        start(14'h2380, 1'b1, 1'b0, 8'h00, 8'h3C, "R8 ch0 read");
        chk("R8 cs ctl0", {cs_ctl, cs_tf}, 4'b0100);
        finish_acc();
        start(14'h3380, 1'b0, 1'b1, 8'h11, 8'h00, "");
        chk("R8 cs ctl1", {cs_ctl, cs_tf}, 4'b1000);
        finish_acc();

        // R11 unmapped
        start(14'h2041, 1'b1, 1'b0, 8'h00, 8'h00, "R11 unaligned");
        chk("R11 unaligned no cs", {cs_tf, cs_ctl}, 0);
        finish_acc();
        wr(14'h1000, 8'hFF);
        rd(14'h1000, 8'h00, "R11 hole");
        rd(14'h0000, 8'h20, "R11 write to hole kept latch");

        // R12 DMA routing
        dreq_in = 2'b01; #1;
        chk("R12 dreq ch0", host_dreq, 1);
        dreq_in = 2'b10; #1;
        chk("R12 dreq ch0 only", host_dreq, 0);
        host_dack = 1'b1; #1;
        chk("R12 dack ch0", dack_out, 2'b01);
        wr(14'h0000, 8'h21);
        settle();
        chk("R12 dreq ch1", host_dreq, 1);
        chk("R12 dack ch1", dack_out, 2'b10);
        host_dack = 1'b0;

        // R9 restore default
        wr(14'h0000, 8'h00);
        start(14'h3000, 1'b1, 1'b0, 8'h00, 8'h00, "R9 restored read");
        chk("R9 restored no cs", {cs_tf, cs_ctl}, 0);
        finish_acc();
        settle();
        chk("R13 all reads consumed", exp_q.size(), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule